// File: doc/BRIEF.md
# Arithmetic Shifter with Condition Flags

This block performs an arithmetic shift on either one 16-bit word or a 32-bit value held as an even/odd register pair. A signed 6-bit count sets both the direction and the distance of the shift. Positive counts shift left. Negative counts shift right, and a right shift fills from the top with copies of the sign bit. Along with the shifted value, the block returns four condition flags. N and Z describe the result. C holds the last bit that left the operand. V reports a left shift that lost bits disagreeing with the sign of the result.

An execution pipeline uses it by presenting the operand words, the count word and a width select, and pulsing a valid strobe. One clock later the registered result and flags appear together with a matching valid. The block does not fetch operands and does not write them back to a register file.

Top module: `ash_unit`

## Requirements
- R1: Only bits [5:0] of `count_i` matter; bits [15:6] have no effect on any output.
- R2: A count of 0 returns the operand unchanged, with C = 0 and V = 0.
- R3: A count k in 1..31 shifts left by k (in the single form, this case covers k in 1..15). C is operand bit (W-k), where W is the selected width. V = 1 when any bit shifted out differs from the result's sign bit.
- R4: In the single form, a count of 16..31 gives a zero result. C is operand bit 0 when the count is exactly 16, and 0 for any larger count. V = 1 exactly when the operand was nonzero.
- R5: A count of 32 shifts right by 32, and a count k in 33..63 shifts right by 64-k. The vacated top bits are filled with the sign bit, C is the last bit shifted out of bit 0, and V = 0.
- R6: When `wide_i` = 1, `op_hi_i` is bits [31:16] and `op_lo_i` is bits [15:0], and the result returns split the same way. When `wide_i` = 0, the operand is `op_lo_i`, the result is on `res_lo_o`, and `res_hi_o` reads 0.
- R7: N is the sign bit of the result and Z is set when the result is zero, both measured at the selected width (16 or 32 bits).
- R8: Result, flags and `out_valid_o` update on the clock edge that samples `in_valid_i` = 1. In any cycle without a strobe, `out_valid_o` is 0 and the result and flags hold their last values. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| wide_i | input | 1 | 1: 32-bit pair form, 0: single 16-bit word |
| op_hi_i | input | 16 | Upper operand half (pair form only) |
| op_lo_i | input | 16 | Lower operand half, or the whole single-form operand |
| count_i | input | 16 | Shift count word; low 6 bits are a two's-complement count |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| res_hi_o | output | 16 | Upper result half (0 in single form) |
| res_lo_o | output | 16 | Lower result half or single-form result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Last bit shifted out |

## Verification
The bench applies every one of the 64 counts to operands that sit on the sign and magnitude edges, in both widths, and compares each result with a bit-serial model. Several failure modes are targeted:
- A design that treats count 32 as a left shift, or decodes 33..63 as a plain magnitude, returns the wrong word and C at the direction boundary.
- A single-form shifter that keeps going past 15 will report C from the sign extension instead of 0, and will miss V for operands such as 0x0001.
- A V computed only from the top operand bit misses sign-losing shifts of 0x7FFF and 0x8000.
- Counts with junk in bits [15:6], and idle cycles between requests, expose decoders that look at the whole word and outputs that fail to hold.

// File: rtl/ash_pkg.sv
package ash_pkg;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2
    } sh_dir_e;

endpackage

// File: rtl/ash_count_decode.sv
module ash_count_decode
    import ash_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] cnt_i,
    output sh_dir_e          dir_o,
    output logic [CNT_W-1:0] amt_o
);

    // The count is two's complement: the top bit selects a right shift, and
    // the distance is then the negated count (the most negative value gives
    // the full half-range, which still fits as an unsigned CNT_W value).
    always_comb begin
        if (cnt_i == '0) begin
            dir_o = SH_NONE;
            amt_o = '0;
        end else if (!cnt_i[CNT_W-1]) begin
            dir_o = SH_LEFT;
            amt_o = cnt_i;
        end else begin
            dir_o = SH_RIGHT;
            amt_o = (~cnt_i) + 1'b1;
        end
    end

endmodule

// File: rtl/ash_shift_core.sv
module ash_shift_core
    import ash_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic                  wide_i,
    input  logic [WORD_W-1:0]     x_hi_i,
    input  logic [WORD_W-1:0]     x_lo_i,
    input  sh_dir_e               dir_i,
    input  logic [CNT_W-1:0]      amt_i,
    output logic [2*WORD_W-1:0]   res_o,
    output logic                  c_o,
    output logic                  v_o
);

    localparam int FULL_W = 2 * WORD_W;
    localparam int EXT_W  = 2 * FULL_W;

    logic [FULL_W-1:0] x_full;
    logic [EXT_W-1:0]  ext;
    logic [EXT_W-1:0]  lsh;
    logic [FULL_W-1:0] rsh;
    logic              sign_left;
    logic              v_wide;
    logic              v_single;

    // A single word is sign-extended so one datapath serves both widths.
    assign x_full = wide_i ? {x_hi_i, x_lo_i} : {{WORD_W{x_lo_i[WORD_W-1]}}, x_lo_i};
    assign ext    = {{FULL_W{x_full[FULL_W-1]}}, x_full};

    // Left: everything above the selected width is what left the word.
    assign lsh       = ext << amt_i;
    assign sign_left = wide_i ? lsh[FULL_W-1] : lsh[WORD_W-1];
    assign v_wide    = |(lsh[EXT_W-1:FULL_W] ^ {FULL_W{sign_left}});
    assign v_single  = |(lsh[EXT_W-1:WORD_W] ^ {(EXT_W-WORD_W){sign_left}});

    // Right: arithmetic shift of the sign-extended value covers both widths.
    assign rsh = $signed(x_full) >>> amt_i;

    always_comb begin
        res_o = '0;
        c_o   = 1'b0;
        v_o   = 1'b0;
        unique case (dir_i)
            SH_LEFT: begin
                if (wide_i) begin
                    res_o = lsh[FULL_W-1:0];
                    c_o   = lsh[FULL_W];
                    v_o   = v_wide;
                end else begin
                    res_o = {{WORD_W{1'b0}}, lsh[WORD_W-1:0]};
                    c_o   = lsh[WORD_W];
                    v_o   = v_single;
                end
            end
            SH_RIGHT: begin
                res_o = wide_i ? rsh : {{WORD_W{1'b0}}, rsh[WORD_W-1:0]};
                c_o   = ext[amt_i - 1'b1];
            end
            default: begin
                res_o = wide_i ? x_full : {{WORD_W{1'b0}}, x_lo_i};
            end
        endcase
    end

endmodule

// File: rtl/ash_unit.sv
module ash_unit
    import ash_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic              wide_i,
    input  logic [WORD_W-1:0] op_hi_i,
    input  logic [WORD_W-1:0] op_lo_i,
    input  logic [WORD_W-1:0] count_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] res_hi_o,
    output logic [WORD_W-1:0] res_lo_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_v_o,
    output logic              flag_c_o
);

    localparam int FULL_W = 2 * WORD_W;
    localparam int CNT_W  = $clog2(FULL_W) + 1;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
    } out_t;

    out_t st_d, st_q;

    sh_dir_e           dir;
    logic [CNT_W-1:0]  amt;
    logic [FULL_W-1:0] core_res;
    logic              core_c;
    logic              core_v;
    logic              cnt_unused;

    // Bits above the count field are ignored by definition.
    assign cnt_unused = ^count_i[WORD_W-1:CNT_W];

    ash_count_decode #(.CNT_W(CNT_W)) u_dec (
        .cnt_i (count_i[CNT_W-1:0]),
        .dir_o (dir),
        .amt_o (amt)
    );

    ash_shift_core #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_core (
        .wide_i (wide_i),
        .x_hi_i (op_hi_i),
        .x_lo_i (op_lo_i),
        .dir_i  (dir),
        .amt_i  (amt),
        .res_o  (core_res),
        .c_o    (core_c),
        .v_o    (core_v)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        if (in_valid_i) begin
            st_d.hi = core_res[FULL_W-1:WORD_W];
            st_d.lo = core_res[WORD_W-1:0];
            st_d.n  = wide_i ? core_res[FULL_W-1] : core_res[WORD_W-1];
            st_d.z  = wide_i ? (core_res == '0) : (core_res[WORD_W-1:0] == '0);
            st_d.v  = core_v;
            st_d.c  = core_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign res_hi_o    = st_q.hi;
    assign res_lo_o    = st_q.lo;
    assign flag_n_o    = st_q.n;
    assign flag_z_o    = st_q.z;
    assign flag_v_o    = st_q.v;
    assign flag_c_o    = st_q.c;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && $stable(res_hi_o) && $stable(res_lo_o)
                         && $stable(flag_c_o) && $stable(flag_v_o)));

    p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && count_i[CNT_W-1:0] == '0) |=>
            (res_lo_o == $past(op_lo_i) && !flag_c_o && !flag_v_o));

    p_right_no_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && count_i[CNT_W-1]) |=> !flag_v_o);

    p_single_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !wide_i) |=> (res_hi_o == '0));

    p_nz_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !(flag_n_o && flag_z_o));

endmodule

// File: tb/ash_unit_tb.sv
module ash_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [15:0] op_hi_i = '0;
    logic [15:0] op_lo_i = '0;
    logic [15:0] count_i = '0;
    logic        out_valid_o;
    logic [15:0] res_hi_o, res_lo_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ash_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .wide_i(wide_i),
        .op_hi_i(op_hi_i), .op_lo_i(op_lo_i), .count_i(count_i),
        .out_valid_o(out_valid_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    typedef struct {
        logic [15:0] hi;
        logic [15:0] lo;
        logic        n, z, v, c;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bit-serial reference model: one bit position per step.
    function automatic exp_t model(input logic w, input logic [15:0] hi,
                                   input logic [15:0] lo, input logic [15:0] cw);
        exp_t e;
        int k = int'(cw[5:0]);
        int width = w ? 32 : 16;
        int steps;
        logic [31:0] cur;
        logic c = 1'b0, v = 1'b0, seen0 = 1'b0, seen1 = 1'b0, sgn;
        cur = w ? {hi, lo} : {16'h0, lo};
        if (k == 0) begin
            e.tag = "R2";
        end else if (k < 32) begin
            e.tag = (!w && k >= 16) ? "R4" : "R3";
            for (int i = 0; i < k; i++) begin
                c = cur[width-1];
                seen1 |= c;
                seen0 |= !c;
                cur = cur << 1;
                if (!w) cur[31:16] = 16'h0;
            end
            v = cur[width-1] ? seen0 : seen1;
        end else begin
            e.tag = "R5";
            steps = (k == 32) ? 32 : 64 - k;
            for (int i = 0; i < steps; i++) begin
                c = cur[0];
                sgn = cur[width-1];
                cur = cur >> 1;
                cur[width-1] = sgn;
            end
        end
        if (cw[15:6] != 0) e.tag = {e.tag, "+R1"};
        e.hi = w ? cur[31:16] : 16'h0;
        e.lo = cur[15:0];
        e.n  = cur[width-1];
        e.z  = w ? (cur == 0) : (cur[15:0] == 0);
        e.v  = v;
        e.c  = c;
        return e;
    endfunction

    task automatic drive(input logic w, input logic [15:0] hi, input logic [15:0] lo,
                         input logic [15:0] cw);
        @(negedge clk);
        in_valid_i = 1'b1;
        wide_i = w;
        op_hi_i = hi;
        op_lo_i = lo;
        count_i = cw;
        sbq.push_back(model(w, hi, lo, cw));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
            op_lo_i = 16'hDEAD;
            count_i = 16'h0005;
        end
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8", "out_valid without request", 32'(out_valid_o), 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check({res_hi_o, res_lo_o} == {e.hi, e.lo}, {e.tag, "/R6"}, "result",
                      {res_hi_o, res_lo_o}, {e.hi, e.lo});
                check({flag_n_o, flag_z_o} == {e.n, e.z}, "R7", "N,Z",
                      32'({flag_n_o, flag_z_o}), 32'({e.n, e.z}));
                check({flag_v_o, flag_c_o} == {e.v, e.c}, e.tag, "V,C",
                      32'({flag_v_o, flag_c_o}), 32'({e.v, e.c}));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ops_s [6];
        logic [31:0] ops_w [6];
        logic [15:0] snap_lo, snap_hi;
        logic [1:0]  snap_f;
        ops_s = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5A3C};
        ops_w = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                  32'hFFFF_FFFF, 32'h1234_8765};

        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid_o == 1'b0, "R8", "reset out_valid", 32'(out_valid_o), 32'h0);
        check({res_hi_o, res_lo_o} == 32'h0, "R8", "reset result",
              {res_hi_o, res_lo_o}, 32'h0);
        check({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == 4'h0, "R8", "reset flags",
              32'({flag_n_o, flag_z_o, flag_v_o, flag_c_o}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Full count sweep, both widths, back to back (R2..R7)
        for (int i = 0; i < 6; i++)
            for (int k = 0; k < 64; k++)
                drive(1'b0, 16'hA5A5, ops_s[i], 16'(k));
        for (int i = 0; i < 6; i++)
            for (int k = 0; k < 64; k++)
                drive(1'b1, ops_w[i][31:16], ops_w[i][15:0], 16'(k));

        // R1: junk in the upper count bits, with gaps between requests
        for (int k = 0; k < 64; k += 7) begin
            drive(1'b0, 16'h0, 16'hC003, {10'h2B5, 6'(k)});
            drive(1'b1, 16'h4001, 16'h8002, {10'h3FF, 6'(k)});
            idle(k % 3);
        end

        // R8: outputs hold while idle
        idle(2);
        @(negedge clk);
        snap_lo = res_lo_o;
        snap_hi = res_hi_o;
        snap_f  = {flag_v_o, flag_c_o};
        idle(3);
        check(out_valid_o == 1'b0, "R8", "idle out_valid", 32'(out_valid_o), 32'h0);
        check({res_hi_o, res_lo_o} == {snap_hi, snap_lo}, "R8", "idle hold",
              {res_hi_o, res_lo_o}, {snap_hi, snap_lo});
        check({flag_v_o, flag_c_o} == snap_f, "R8", "idle hold flags",
              32'({flag_v_o, flag_c_o}), 32'(snap_f));
        check(sbq.size() == 0, "R8", "pending results", 32'(sbq.size()), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule